// File: doc/BRIEF.md
# Capture-Compare General Purpose Timer

This block is a general purpose counter with a programmable prescaler, one compare channel and one capture channel. Software sets it up through a small write/read register port. It then runs in one of two ways. In free-running mode the counter passes through its whole range and wraps. In restart mode the counter returns to zero once it has reached the compare value, which gives a periodic compare event.

The counter counts prescaled ticks. A tick source is either every system clock or each rising edge of an external clock pin. The external clock pin and the capture pin each pass through a two-flop synchronizer. Edges on these pins are detected in the system clock domain. A capture edge copies the live counter value into the capture register. Three sticky status flags record compare matches, captures and rollovers. They feed one interrupt line through per-flag enables.

The control flow is a three-state machine: ST_IDLE (stopped, counter holds), ST_FREE (free-running) and ST_RESTART (restart on compare). The named transitions are:
- START: ST_IDLE to ST_FREE or ST_RESTART when enable is set. The counter and the prescaler are cleared on this transition.
- STOP: either running state to ST_IDLE when enable is cleared.
- TO_RESTART and TO_FREE: a switch between the two running states when the mode bit changes. The count is kept.

Top module: `cct_timer`

## Requirements
- R1: After reset the counter, the capture value, all status bits and irq read 0.
- R2: Register addresses are 0 control, 1 prescale, 2 compare, 3 capture (read only), 4 count (read only) and 5 status. Control bit 0 enables the counter. Setting it from the stopped state clears the counter. The counter then advances by one every p+1 tick-source events, where p is the prescale value. With the internal source every clock cycle is an event.
- R3: While control bit 0 is clear, the counter holds its value.
- R4: With control bit 1 clear (free-running), a tick at all ones moves the counter to 0 and sets status bit 2 (rollover).
- R5: With control bit 1 set (restart), a tick while the counter equals the compare value moves it to 0. One period is therefore compare+1 ticks.
- R6: Status bit 0 is set on the tick that makes the counter equal to the compare value.
- R7: In restart mode a compare write takes effect only after the current period has ended. It never shortens the running period.
- R8: With control bit 2 set, the tick source is each rising edge of ext_clk_in after two-flop synchronization. The system clock is then not counted.
- R9: Control bits 4:3 select the capture edge of cap_in: 00 none, 01 rising, 10 falling, 11 both. A selected edge latches the count into the capture register and sets status bit 1. An edge that is not selected changes neither.
- R10: Status bits are sticky and are cleared by writing 1 to them at address 5. irq is high when any status bit is set whose enable is set. The enables are control bit 5 for compare, bit 6 for capture and bit 7 for rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_in | input | 1 | Asynchronous external tick source |
| cap_in | input | 1 | Asynchronous capture event input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the timer with an 8-bit counter and a 4-bit prescale field. With these values the all-ones wrap and the rollover flag can be reached after 256 ticks. The same datapath is used at the full 32-bit default. The short prescale field still allows several divide ratios to be checked against exact counts. Compare values of a few ticks let the bench see whole restart periods, including a compare write made in the middle of a period.

// File: rtl/cct_pkg.sv
package cct_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FREE    = 2'd1,
        ST_RESTART = 2'd2
    } run_state_t;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } cap_edge_t;

    typedef struct packed {
        logic      ie_roll;
        logic      ie_cap;
        logic      ie_cmp;
        cap_edge_t edge_sel;
        logic      ext_src;
        logic      restart;
        logic      enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int STAT_W = 3;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_PRESC = 3'd1;
    localparam logic [2:0] A_CMP   = 3'd2;
    localparam logic [2:0] A_CAP   = 3'd3;
    localparam logic [2:0] A_CNT   = 3'd4;
    localparam logic [2:0] A_STAT  = 3'd5;

    localparam int S_CMP  = 0;
    localparam int S_CAP  = 1;
    localparam int S_ROLL = 2;

endpackage

// File: rtl/cct_sync.sv
module cct_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_q,
    output logic prev_q
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], async_in};
    end

    assign sync_q = chain_q[STAGES-1];
    assign prev_q = chain_q[STAGES];
endmodule

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             event_i,
    input  logic [PRE_W-1:0] divide,
    output logic             tick
);
    logic [PRE_W-1:0] acc_q;

    assign tick = event_i && (acc_q >= divide);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc_q <= '0;
        else if (clear)   acc_q <= '0;
        else if (event_i) acc_q <= tick ? '0 : acc_q + 1'b1;
    end
endmodule

// File: rtl/cct_capture.sv
module cct_capture
    import cct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cap_edge_t        edge_sel,
    input  logic             rise,
    input  logic             fall,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_hit
);
    always_comb begin
        unique case (edge_sel)
            EDGE_RISE: cap_hit = rise;
            EDGE_FALL: cap_hit = fall;
            EDGE_BOTH: cap_hit = rise | fall;
            default:   cap_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cap_val <= '0;
        else if (cap_hit) cap_val <= count_i;
    end
endmodule

// File: rtl/cct_timer.sv
module cct_timer
    import cct_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_in,
    input  logic             cap_in,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    ctrl_t             ctrl_q;
    logic [PRE_W-1:0]  presc_q;
    logic [CNT_W-1:0]  cmp_shadow_q;
    logic [CNT_W-1:0]  cmp_act;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [CNT_W-1:0]  cap_val;
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] stat_set;
    logic [STAT_W-1:0] stat_clr;
    run_state_t        state_q, state_d;

    logic ext_s, ext_p, cap_s, cap_p;
    logic ext_rise, cap_rise, cap_fall, cap_hit;
    logic running, start, src_evt, tick, wrap_pt;

    // input synchronizers
    cct_sync #(.STAGES(2)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_clk_in), .sync_q(ext_s), .prev_q(ext_p));
    cct_sync #(.STAGES(2)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .async_in(cap_in), .sync_q(cap_s), .prev_q(cap_p));

    assign ext_rise = ext_s & ~ext_p;
    assign cap_rise = cap_s & ~cap_p;
    assign cap_fall = ~cap_s & cap_p;

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q       <= '0;
            presc_q      <= '0;
            cmp_shadow_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_CTRL:  ctrl_q       <= ctrl_t'(wr_data[CTRL_W-1:0]);
                A_PRESC: presc_q      <= wr_data[PRE_W-1:0];
                A_CMP:   cmp_shadow_q <= wr_data;
                default: ;
            endcase
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_q.enable) state_d = ctrl_q.restart ? ST_RESTART : ST_FREE;
            end
            ST_FREE: begin
                if (!ctrl_q.enable)      state_d = ST_IDLE;
                else if (ctrl_q.restart) state_d = ST_RESTART;
            end
            ST_RESTART: begin
                if (!ctrl_q.enable)       state_d = ST_IDLE;
                else if (!ctrl_q.restart) state_d = ST_FREE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // state-derived controls
    always_comb begin
        running = 1'b0;
        wrap_pt = 1'b0;
        unique case (state_q)
            ST_FREE:    running = 1'b1;
            ST_RESTART: begin
                running = 1'b1;
                wrap_pt = (cnt_q == cmp_act);
            end
            default: ;
        endcase
    end

    assign start   = (state_q == ST_IDLE) && (state_d != ST_IDLE);
    assign src_evt = running && (ctrl_q.ext_src ? ext_rise : 1'b1);
    assign cnt_nxt = wrap_pt ? '0 : cnt_q + 1'b1;

    cct_prescaler #(.PRE_W(PRE_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .clear(!running), .event_i(src_evt),
        .divide(presc_q), .tick(tick));

    // counter and active compare
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (start) cnt_q <= '0;
        else if (tick)  cnt_q <= cnt_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cmp_act <= '0;
        else if (state_q != ST_RESTART)  cmp_act <= cmp_shadow_q;
        else if (tick && wrap_pt)        cmp_act <= cmp_shadow_q;
    end

    cct_capture #(.CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .edge_sel(ctrl_q.edge_sel), .rise(cap_rise),
        .fall(cap_fall), .count_i(cnt_q), .cap_val(cap_val), .cap_hit(cap_hit));

    // sticky status, write-one-to-clear
    always_comb begin
        stat_set         = '0;
        stat_set[S_CMP]  = tick && (cnt_nxt == cmp_act);
        stat_set[S_CAP]  = cap_hit;
        stat_set[S_ROLL] = tick && (state_q == ST_FREE) && (&cnt_q);
        stat_clr = (wr_en && wr_addr == A_STAT) ? wr_data[STAT_W-1:0] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~stat_clr) | stat_set;
    end

    assign irq = |(status_q & {ctrl_q.ie_roll, ctrl_q.ie_cap, ctrl_q.ie_cmp});

    // read mux
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL:  rd_data[CTRL_W-1:0] = ctrl_q;
            A_PRESC: rd_data[PRE_W-1:0]  = presc_q;
            A_CMP:   rd_data             = cmp_shadow_q;
            A_CAP:   rd_data             = cap_val;
            A_CNT:   rd_data             = cnt_q;
            A_STAT:  rd_data[STAT_W-1:0] = status_q;
            default: rd_data             = '0;
        endcase
    end
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk
    import cct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input run_state_t       state_q,
    input logic             start,
    input logic             tick,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cmp_act,
    input logic [2:0]       status_q,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input cap_edge_t        edge_sel,
    input logic             cap_hit,
    input logic [CNT_W-1:0] cap_val
);
    // R3
    hold_when_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(cnt_q));

    // R5
    restart_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESTART && tick && cnt_q == cmp_act) |=> (cnt_q == '0));

    // R4
    rollover_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FREE && tick && (&cnt_q)) |=> status_q[2]);

    // R10
    cmp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[0] && !(wr_en && wr_addr == 3'd5 && wr_data[0])) |=> status_q[0]);

    // R9
    cap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel == EDGE_OFF) |-> !cap_hit);

    // R9
    cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> (cap_val == $past(cnt_q)));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == '0));
endmodule

bind cct_timer cct_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .start(start), .tick(tick),
    .cnt_q(cnt_q), .cmp_act(cmp_act), .status_q(status_q), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .edge_sel(ctrl_q.edge_sel),
    .cap_hit(cap_hit), .cap_val(cap_val));

// File: tb/cct_timer_tb.sv
module cct_timer_tb_top;
    localparam int CNT_W = 8;
    localparam int PRE_W = 4;
    localparam int NVEC  = 4;

    // {prescale, cycles after enable write, expected count}
    localparam logic [23:0] VEC [NVEC] = '{
        {8'd0, 8'd10, 8'd9},
        {8'd1, 8'd11, 8'd5},
        {8'd3, 8'd21, 8'd5},
        {8'd2, 8'd7,  8'd2}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ext_clk_in = 1'b0;
    logic             cap_in = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [2:0]       rd_addr = '0;
    logic [CNT_W-1:0] rd_data;
    logic             irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cct_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_clk_in(ext_clk_in), .cap_in(cap_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input logic [2:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_all();
        wr(3'd0, 0);
        wr(3'd1, 0);
        wr(3'd5, 7);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v;
        int v2;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);

        // R1 reset state
        rd(3'd4, v); check("R1 count", v, 0);
        rd(3'd5, v); check("R1 status", v, 0);
        rd(3'd3, v); check("R1 capture", v, 0);
        check("R1 irq", int'(irq), 0);

        // R2 prescaled counting, table walk
        for (int i = 0; i < NVEC; i++) begin
            stop_all();
            wr(3'd1, int'(VEC[i][23:16]));
            wr(3'd0, 1);
            wait_n(int'(VEC[i][15:8]));
            rd(3'd4, v); check("R2 prescaled count", v, int'(VEC[i][7:0]));
        end

        // R3 hold while disabled
        stop_all();
        wr(3'd0, 1);
        wait_n(9);
        wr(3'd0, 0);
        wait_n(5);
        rd(3'd4, v); check("R3 held count", v, 10);
        wait_n(5);
        rd(3'd4, v); check("R3 still held", v, 10);

        // R4 rollover in free-running mode
        stop_all();
        wr(3'd2, 100);
        wr(3'd0, 1);
        wait_n(256);
        rd(3'd4, v); check("R4 all ones", v, 255);
        rd(3'd5, v); check("R4 no rollover yet", v & 4, 0);
        wait_n(1);
        rd(3'd4, v); check("R4 wrapped", v, 0);
        rd(3'd5, v); check("R4 rollover flag", v & 4, 4);
        wr(3'd5, 4);
        rd(3'd5, v); check("R10 rollover cleared", v & 4, 0);

        // R5 R6 restart mode
        stop_all();
        wr(3'd2, 4);
        wr(3'd0, 3);
        wait_n(4);
        rd(3'd5, v); check("R6 no compare yet", v & 1, 0);
        wait_n(1);
        rd(3'd4, v); check("R5 at compare", v, 4);
        rd(3'd5, v); check("R6 compare flag", v & 1, 1);
        wait_n(1);
        rd(3'd4, v); check("R5 restarted", v, 0);
        wait_n(5);
        rd(3'd4, v); check("R5 second period", v, 0);
        rd(3'd5, v); check("R5 no rollover in restart", v & 4, 0);

        // R7 compare change mid-period
        stop_all();
        wr(3'd2, 4);
        wr(3'd0, 3);
        wait_n(2);
        wr(3'd2, 2);
        wait_n(2);
        rd(3'd4, v); check("R7 period not truncated", v, 4);
        wait_n(3);
        rd(3'd4, v); check("R7 new period peak", v, 2);
        wait_n(1);
        rd(3'd4, v); check("R7 new period wrap", v, 0);

        // R10 interrupt masking and clear
        stop_all();
        wr(3'd2, 3);
        wr(3'd0, 8'h23);
        wait_n(5);
        check("R10 irq on compare", int'(irq), 1);
        wr(3'd0, 8'h20);
        wait_n(2);
        check("R10 irq sticky", int'(irq), 1);
        wr(3'd5, 1);
        check("R10 irq cleared", int'(irq), 0);
        stop_all();
        wr(3'd2, 3);
        wr(3'd0, 8'h03);
        wait_n(5);
        rd(3'd5, v); check("R10 flag without enable", v & 1, 1);
        check("R10 irq masked", int'(irq), 0);

        // R8 external clock source
        stop_all();
        wr(3'd0, 8'h05);
        wait_n(10);
        rd(3'd4, v); check("R8 no internal counting", v, 0);
        for (int p = 0; p < 6; p++) begin
            ext_clk_in = 1'b1; wait_n(3);
            ext_clk_in = 1'b0; wait_n(3);
        end
        wait_n(5);
        rd(3'd4, v); check("R8 external edges", v, 6);

        // R9 capture edge selection
        stop_all();
        wr(3'd0, 1);
        wait_n(20);
        wr(3'd0, 8'h08);
        wait_n(3);
        cap_in = 1'b1; wait_n(5);
        rd(3'd3, v); check("R9 captured value", v, 21);
        rd(3'd5, v); check("R9 rising flag", v & 2, 2);
        wr(3'd5, 2);
        cap_in = 1'b0; wait_n(5);
        rd(3'd5, v); check("R9 falling ignored in rise mode", v & 2, 0);
        wr(3'd0, 8'h10);
        cap_in = 1'b1; wait_n(5);
        rd(3'd5, v); check("R9 rising ignored in fall mode", v & 2, 0);
        cap_in = 1'b0; wait_n(5);
        rd(3'd5, v); check("R9 falling flag", v & 2, 2);
        wr(3'd5, 2);
        wr(3'd0, 8'h18);
        cap_in = 1'b1; wait_n(5);
        rd(3'd5, v); check("R9 both rising", v & 2, 2);
        wr(3'd5, 2);
        cap_in = 1'b0; wait_n(5);
        rd(3'd5, v); check("R9 both falling", v & 2, 2);
        wr(3'd5, 2);
        wr(3'd0, 8'h00);
        rd(3'd3, v2);
        cap_in = 1'b1; wait_n(5);
        rd(3'd5, v); check("R9 off mode no flag", v & 2, 0);
        rd(3'd3, v); check("R9 off mode no capture", v, v2);
        cap_in = 1'b0; wait_n(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule